// File: doc/BRIEF.md
# Hex Record Stream Loader

This block turns a stream of ASCII characters into memory writes. Characters arrive one per valid/ready handshake. Each record opens with a colon. The text that follows is read as bytes of two hex characters each: a count, a 16-bit load offset, a record kind, the payload and a closing checksum byte. The block keeps the payload in a small buffer until the checksum has been checked. Only a record that passes is released to the write port, one byte per cycle.

A segment record sets a 16-bit segment value. Every later data byte is placed at that value times sixteen plus its offset, within a 20-bit space. An end-of-file record stops loading for good. Three sticky flags report a failed checksum, an unsupported record kind and a malformed character. The block is meant to sit between a serial text source and a memory or bus write master during bootstrap loading.

Top module: `hexrec_loader`

States: `ST_HUNT` waits for a colon. `ST_LEN`, `ST_ADDR`, `ST_TYPE`, `ST_DATA` and `ST_SUM` gather the fields in that order. `ST_WRITE` drains the buffer. `ST_END` absorbs everything after end of file.

Transitions:
- HUNT→LEN on a colon.
- LEN→ADDR on the count byte, or LEN→HUNT when the count is over the limit.
- ADDR→TYPE after two offset bytes.
- TYPE→DATA, or TYPE→SUM when the count is zero.
- DATA→SUM after the last payload byte.
- SUM→WRITE for a passing data record with payload.
- SUM→END for a passing end-of-file record.
- SUM→HUNT in every other case.
- WRITE→HUNT after the last byte.
- Any gathering state→HUNT on a bad character, or →LEN when that character is a colon.

## Requirements
- R1: Each byte of a passing data record (kind 00) is written once, in order, to offsets that run up from the load offset. Writes go one per cycle. The first write is presented in the cycle right after the checksum's second character is accepted. `in_ready` is low for every write cycle.
- R2: The write address is segment×16 plus the offset, truncated to 20 bits. The offset itself wraps within 16 bits. The segment is zero after reset.
- R3: A passing record of kind 02 with count 02 loads the segment from its two payload bytes, high byte first, and causes no write.
- R4: A record whose bytes, from the count through the checksum, do not add to zero modulo 256 writes nothing and sets the sticky `err_csum`. Later good records still load.
- R5: A passing record of kind 01 raises `done`, which then stays high. Later characters are still accepted but cause no writes and no flag changes.
- R6: A passing record of any other kind, or of kind 02 with a count other than 02, sets the sticky `err_type`. It writes nothing and leaves the segment as it was.
- R7: The digits 0-9, A-F and a-f are all accepted as hex.
- R8: Inside a record, any character other than a hex digit, CR (0x0D) or LF (0x0A) sets the sticky `err_fmt` and drops the record. If that character is a colon, a new record starts. Outside a record, every character except a colon is ignored.
- R9: A count above `MAX_LEN` sets `err_fmt` and drops the record with no writes.
- R10: After synchronous reset (`rst_n` low at a clock edge), `in_ready` is 1 and `wr_en`, `done` and all three flags are 0.
- R11: CR and LF are skipped anywhere, including between the two characters of a field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | ASCII character |
| in_valid | input | 1 | Character present |
| in_ready | output | 1 | Character taken when high with in_valid |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 20 | Physical write address |
| wr_data | output | 8 | Write byte |
| done | output | 1 | End-of-file record accepted |
| err_csum | output | 1 | Sticky checksum failure |
| err_type | output | 1 | Sticky unsupported record kind |
| err_fmt | output | 1 | Sticky malformed character or oversize count |

## Verification
A character is taken at the clock edge where `in_valid` and `in_ready` are both high. Flags and `done` change at that same edge. The first write of a data record is on the ports in the cycle right after the edge that takes its final checksum character, and the remaining bytes follow on successive cycles. The bench drives at falling edges and checks the one-cycle write latency at the falling edge right after the checksum is taken. It records every write strobe at falling edges and compares the collected addresses and bytes only after a settling gap longer than the largest record.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_ADDR,
        ST_TYPE,
        ST_DATA,
        ST_SUM,
        ST_WRITE,
        ST_END
    } ldr_state_t;

    localparam logic [7:0] KIND_DATA = 8'h00;
    localparam logic [7:0] KIND_EOF  = 8'h01;
    localparam logic [7:0] KIND_SEG  = 8'h02;

    localparam logic [7:0] CH_MARK = 8'h3A;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;

endpackage

// File: rtl/hexrec_char_class.sv
module hexrec_char_class
    import hexrec_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic       is_mark,
    output logic       is_eol,
    output logic [3:0] nib
);
    logic [7:0] diff;

    always_comb begin
        is_hex = 1'b0;
        diff   = 8'h00;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            diff   = ch - 8'h30;
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            diff   = ch - 8'h37;
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            is_hex = 1'b1;
            diff   = ch - 8'h57;
        end
        nib     = diff[3:0];
        is_mark = (ch == CH_MARK);
        is_eol  = (ch == CH_CR) || (ch == CH_LF);
    end
endmodule

// File: rtl/hexrec_payload_buf.sv
module hexrec_payload_buf #(
    parameter int DEPTH = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hexrec_addr_gen.sv
module hexrec_addr_gen (
    input  logic [15:0] seg,
    input  logic [15:0] base,
    input  logic [7:0]  step,
    output logic [19:0] phys
);
    logic [15:0] off;

    always_comb begin
        off  = base + {8'h00, step};
        phys = {seg, 4'h0} + {4'h0, off};
    end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
#(
    parameter int MAX_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        wr_en,
    output logic [19:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        done,
    output logic        err_csum,
    output logic        err_type,
    output logic        err_fmt
);
    localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

    ldr_state_t state, nxt;

    logic       is_hex, is_mark, is_eol;
    logic [3:0] nib;
    logic       take, in_rec, bad_char, byte_done, sum_ok, last_byte;
    logic       phase;
    logic [3:0] hi_nib;
    logic [7:0] full_byte, sum, sum_next, len, rtype, idx;
    logic [15:0] load_addr, seg, seg_cand;
    logic       f_csum, f_type, f_fmt;

    hexrec_char_class u_class (
        .ch      (in_data),
        .is_hex  (is_hex),
        .is_mark (is_mark),
        .is_eol  (is_eol),
        .nib     (nib)
    );

    hexrec_payload_buf #(.DEPTH(MAX_LEN)) u_buf (
        .clk   (clk),
        .we    (byte_done && state == ST_DATA),
        .waddr (idx[IW-1:0]),
        .wdata (full_byte),
        .raddr (idx[IW-1:0]),
        .rdata (wr_data)
    );

    hexrec_addr_gen u_agen (
        .seg  (seg),
        .base (load_addr),
        .step (idx),
        .phys (wr_addr)
    );

    assign in_rec    = (state == ST_LEN) || (state == ST_ADDR) || (state == ST_TYPE) ||
                       (state == ST_DATA) || (state == ST_SUM);
    assign take      = in_valid && in_ready;
    assign bad_char  = take && in_rec && !is_hex && !is_eol;
    assign byte_done = take && in_rec && is_hex && phase;
    assign full_byte = {hi_nib, nib};
    assign sum_next  = sum + full_byte;
    assign sum_ok    = (sum_next == 8'h00);
    assign last_byte = (idx == len - 8'd1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (take && is_mark) nxt = ST_LEN;
            ST_WRITE: if (last_byte) nxt = ST_HUNT;
            ST_END:   nxt = ST_END;
            default: begin
                if (bad_char) begin
                    nxt = is_mark ? ST_LEN : ST_HUNT;
                end else if (byte_done) begin
                    unique case (state)
                        ST_LEN:  nxt = (full_byte > LEN_LIMIT) ? ST_HUNT : ST_ADDR;
                        ST_ADDR: if (idx == 8'd1) nxt = ST_TYPE;
                        ST_TYPE: nxt = (len == 8'd0) ? ST_SUM : ST_DATA;
                        ST_DATA: if (last_byte) nxt = ST_SUM;
                        ST_SUM: begin
                            if (!sum_ok)                                 nxt = ST_HUNT;
                            else if (rtype == KIND_DATA && len != 8'd0)  nxt = ST_WRITE;
                            else if (rtype == KIND_EOF)                  nxt = ST_END;
                            else                                         nxt = ST_HUNT;
                        end
                        default: nxt = state;
                    endcase
                end
            end
        endcase
    end

    // field datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            hi_nib    <= 4'h0;
            len       <= 8'h00;
            rtype     <= 8'h00;
            idx       <= 8'h00;
            sum       <= 8'h00;
            load_addr <= 16'h0000;
            seg       <= 16'h0000;
            seg_cand  <= 16'h0000;
            f_csum    <= 1'b0;
            f_type    <= 1'b0;
            f_fmt     <= 1'b0;
        end else begin
            if (take && is_mark && state == ST_HUNT) begin
                phase <= 1'b0;
            end else if (bad_char) begin
                phase <= 1'b0;
                f_fmt <= 1'b1;
            end else if (take && in_rec && is_hex) begin
                phase <= !phase;
                if (!phase) hi_nib <= nib;
            end

            if (byte_done) begin
                unique case (state)
                    ST_LEN: begin
                        len <= full_byte;
                        sum <= full_byte;
                        idx <= 8'h00;
                        if (full_byte > LEN_LIMIT) f_fmt <= 1'b1;
                    end
                    ST_ADDR: begin
                        load_addr <= {load_addr[7:0], full_byte};
                        sum       <= sum_next;
                        idx       <= idx + 8'd1;
                    end
                    ST_TYPE: begin
                        rtype <= full_byte;
                        sum   <= sum_next;
                        idx   <= 8'h00;
                    end
                    ST_DATA: begin
                        seg_cand <= {seg_cand[7:0], full_byte};
                        sum      <= sum_next;
                        idx      <= idx + 8'd1;
                    end
                    ST_SUM: begin
                        idx <= 8'h00;
                        if (!sum_ok)
                            f_csum <= 1'b1;
                        else if (rtype == KIND_SEG && len == 8'd2)
                            seg <= seg_cand;
                        else if (rtype != KIND_DATA && rtype != KIND_EOF)
                            f_type <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (state == ST_WRITE) idx <= idx + 8'd1;
        end
    end

    // outputs
    always_comb begin
        in_ready = (state != ST_WRITE);
        wr_en    = (state == ST_WRITE);
        done     = (state == ST_END);
        err_csum = f_csum;
        err_type = f_type;
        err_fmt  = f_fmt;
    end
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        wr_en,
    input logic [19:0] wr_addr,
    input logic        done,
    input logic        err_csum,
    input logic        err_type,
    input logic        err_fmt
);
    assert_write_follows_char_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(in_valid && in_ready));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |->
            ((wr_addr - $past(wr_addr)) == 20'h00001 || (wr_addr - $past(wr_addr)) == 20'hF0001));

    assert_csum_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_csum |=> err_csum);

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !wr_en));

    assert_type_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_type |=> err_type);

    assert_fmt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_fmt |=> err_fmt);
endmodule

bind hexrec_loader hexrec_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done),
    .err_csum (err_csum),
    .err_type (err_type),
    .err_fmt  (err_fmt)
);

// File: tb/hexrec_loader_test.sv
module hexrec_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready, wr_en, done, err_csum, err_type, err_fmt;
    logic [19:0] wr_addr;
    logic [7:0]  wr_data;

    hexrec_loader #(.MAX_LEN(16)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err_csum(err_csum), .err_type(err_type), .err_fmt(err_fmt)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int mon_n = 0;
    logic [19:0] mon_a [64];
    logic [7:0]  mon_d [64];
    logic [7:0]  payload [32];
    logic [15:0] seg_m = 16'h0000;
    bit timed_out = 0;

    // {offset, count, seed, mode}: mode bit0 = lowercase, bit1 = CR/LF inside the record
    localparam logic [39:0] VEC [5] = '{
        {16'h0100, 8'd12, 8'h11, 8'h00},
        {16'h2000, 8'd1,  8'hA5, 8'h01},
        {16'hFFFA, 8'd8,  8'h3C, 8'h00},
        {16'h1234, 8'd16, 8'h80, 8'h03},
        {16'h0040, 8'd5,  8'hF0, 8'h02}
    };

    always @(negedge clk) begin
        if (wr_en && mon_n < 64) begin
            mon_a[mon_n] = wr_addr;
            mon_d[mon_n] = wr_data;
            mon_n = mon_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] v, input bit lc);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lc ? 8'h57 : 8'h37) + {4'h0, v};
    endfunction

    task automatic send_char(input logic [7:0] c);
        in_data  = c;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lc);
        send_char(hexch(b[7:4], lc));
        send_char(hexch(b[3:0], lc));
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic send_rec(input logic [15:0] a, input logic [7:0] t, input int n,
                            input bit lc, input bit crmid, input bit badsum);
        logic [7:0] s;
        s = n[7:0] + a[15:8] + a[7:0] + t;
        for (int k = 0; k < n; k++) s = s + payload[k];
        s = 8'h00 - s;
        if (badsum) s = s + 8'h01;
        send_char(8'h3A);
        send_byte(n[7:0], lc);
        send_byte(a[15:8], lc);
        if (crmid) begin
            send_char(8'h0D);
            send_char(8'h0A);
        end
        send_byte(a[7:0], lc);
        send_char(hexch(t[7:4], lc));
        if (crmid) send_char(8'h0D);
        send_char(hexch(t[3:0], lc));
        for (int k = 0; k < n; k++) send_byte(payload[k], lc);
        send_byte(s, lc);
    endtask

    task automatic settle_clear();
        repeat (40) @(negedge clk);
    endtask

    task automatic verify(input string req, input logic [15:0] a, input int n);
        logic [15:0] off;
        logic [19:0] ea;
        chk(req, mon_n, n);
        for (int k = 0; k < n && k < mon_n; k++) begin
            off = a + k[15:0];
            ea  = {seg_m, 4'h0} + {4'h0, off};
            chk(req, {12'h000, mon_a[k]}, {12'h000, ea});
            chk(req, {24'h0, mon_d[k]}, {24'h0, payload[k]});
        end
        mon_n = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seg_m = 16'h0000;
        mon_n = 0;
    endtask

    task automatic run_tests();
        logic [39:0] v;
        do_reset();
        // R10 reset state
        chk("R10 in_ready", in_ready, 1);
        chk("R10 wr_en", wr_en, 0);
        chk("R10 done", done, 0);
        chk("R10 flags", {err_csum, err_type, err_fmt}, 0);

        // table walk: R1 R2 R7 R11
        for (int i = 0; i < 5; i++) begin
            v = VEC[i];
            for (int k = 0; k < 32; k++) payload[k] = v[15:8] + 8'(k * 37);
            send_rec(v[39:24], 8'h00, int'(v[23:16]), v[0], v[1], 1'b0);
            send_char(8'h0D);
            send_char(8'h0A);
            settle_clear();
            verify("R1 R2 R7 R11 vector", v[39:24], int'(v[23:16]));
        end

        // R1 first write in the cycle after the checksum is taken
        for (int k = 0; k < 32; k++) payload[k] = 8'h40 + k[7:0];
        send_rec(16'h0300, 8'h00, 3, 1'b0, 1'b0, 1'b0);
        chk("R1 write due", wr_en, 1);
        chk("R1 ready low", in_ready, 0);
        settle_clear();
        verify("R1 timing", 16'h0300, 3);

        // R3 segment record then the 12-byte data record
        send_str(":020000021000EC");
        settle_clear();
        chk("R3 no write", mon_n, 0);
        seg_m = 16'h1000;
        {payload[0], payload[1], payload[2], payload[3]} = 32'hBA3412EC;
        {payload[4], payload[5], payload[6], payload[7]} = 32'hF6D0BA78;
        {payload[8], payload[9], payload[10], payload[11]} = 32'h56EEEBF4;
        send_str(":0C000000BA3412ECF6D0BA7856EEEBF4ED");
        settle_clear();
        verify("R3 segment", 16'h0000, 12);

        // R2 offset wrap under a high segment
        payload[0] = 8'hF0; payload[1] = 8'h00;
        send_rec(16'h0000, 8'h02, 2, 1'b0, 1'b0, 1'b0);
        settle_clear();
        seg_m = 16'hF000;
        for (int k = 0; k < 32; k++) payload[k] = 8'h90 ^ k[7:0];
        send_rec(16'hFFF8, 8'h00, 12, 1'b0, 1'b0, 1'b0);
        settle_clear();
        verify("R2 wrap", 16'hFFF8, 12);

        // R6 unsupported kinds, segment kept
        payload[0] = 8'h12; payload[1] = 8'h34;
        send_rec(16'h0000, 8'h03, 2, 1'b0, 1'b0, 1'b0);
        settle_clear();
        chk("R6 flag", err_type, 1);
        chk("R6 no write", mon_n, 0);
        send_rec(16'h0000, 8'h02, 1, 1'b0, 1'b0, 1'b0);
        settle_clear();
        chk("R6 no write seg len1", mon_n, 0);
        chk("R6 other flags", {err_csum, err_fmt}, 0);
        for (int k = 0; k < 32; k++) payload[k] = 8'h07 + k[7:0];
        send_rec(16'h0100, 8'h00, 3, 1'b0, 1'b0, 1'b0);
        settle_clear();
        verify("R6 segment kept", 16'h0100, 3);

        // R4 bad checksum
        chk("R4 clear before", err_csum, 0);
        send_rec(16'h0500, 8'h00, 4, 1'b0, 1'b0, 1'b1);
        settle_clear();
        chk("R4 flag", err_csum, 1);
        chk("R4 no write", mon_n, 0);
        send_rec(16'h0500, 8'h00, 4, 1'b0, 1'b0, 1'b0);
        settle_clear();
        verify("R4 recovery", 16'h0500, 4);

        // R2 segment back to zero after reset, R10 flags cleared
        do_reset();
        chk("R10 flags after reset", {err_csum, err_type, err_fmt}, 0);
        send_rec(16'h0010, 8'h00, 2, 1'b0, 1'b0, 1'b0);
        settle_clear();
        verify("R2 reset segment", 16'h0010, 2);

        // R9 oversize count
        send_rec(16'h0020, 8'h00, 17, 1'b0, 1'b0, 1'b0);
        settle_clear();
        chk("R9 flag", err_fmt, 1);
        chk("R9 no write", mon_n, 0);

        // R8 malformed characters
        do_reset();
        send_str("zq9#");
        send_rec(16'h0600, 8'h00, 2, 1'b0, 1'b0, 1'b0);
        settle_clear();
        chk("R8 outside ignored", err_fmt, 0);
        verify("R8 outside record", 16'h0600, 2);
        send_str(":01G0000");
        settle_clear();
        chk("R8 bad char flag", err_fmt, 1);
        chk("R8 no write", mon_n, 0);
        send_str(":0");
        send_rec(16'h0700, 8'h00, 3, 1'b1, 1'b0, 1'b0);
        settle_clear();
        verify("R8 colon restart", 16'h0700, 3);

        // R5 end of file
        do_reset();
        send_str(":00000001FF");
        @(negedge clk);
        chk("R5 done", done, 1);
        send_rec(16'h0800, 8'h00, 2, 1'b0, 1'b0, 1'b1);
        send_rec(16'h0800, 8'h00, 2, 1'b0, 1'b0, 1'b0);
        settle_clear();
        chk("R5 no write", mon_n, 0);
        chk("R5 done held", done, 1);
        chk("R5 flags unchanged", {err_csum, err_type, err_fmt}, 0);
        chk("R5 ready", in_ready, 1);
    endtask

    initial begin
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule